// File: doc/BRIEF.md
# Hall Counter Capture Unit

The unit measures how long each of three synchronized rotor position signals (U, V and W) has held its level, and keeps a free-running timer beside those counts. The live values form a group of four words. Three more copies of that group are kept: a read copy, filled by a software command or by any enabled phase event, and two snapshot copies, filled in turn by an external snap input.

For each position signal the unit also keeps two history words. One holds the count reached just before the signal rose, the other the count reached just before it fell. A clear control empties every counter, copy and history word. All contents reach the bus side through one registered read port; the address decoding of the bus itself sits outside this block.

Top module: `hall_capture_unit`

## Requirements
- R1: Each signal counter is zeroed on the clock edge that samples a new level on its input, and then gains one per clock. A read command sampled k edges after that edge captures k-1.
- R2: A signal counter stops at its all-ones value (2^CNT_W-1, with CNT_W=28 by default) and does not wrap.
- R3: The timer (TMR_W=32 bits) gains one on every clock and wraps. Two samples of the live timer taken n clocks apart differ by n.
- R4: A high rd_cmd on a clock edge copies the four live words into the read copy (bank 1) on that same edge.
- R5: A pulse on evt_pulse[i] loads the read copy exactly like rd_cmd when evt_load_en[i] is 1. When evt_load_en[i] is 0, the pulse leaves the read copy unchanged.
- R6: While snap_en is 1, each 0-to-1 change of snap_in loads the live words into one snapshot copy, alternating bank 2, bank 3, bank 2 and so on, starting with bank 2. While snap_en is 0, snap_in loads nothing.
- R7: When a read load and a snap load happen on the same edge, both target copies receive identical words.
- R8: On a 0-to-1 change of a signal, its rising history word takes that signal's count from just before the edge. On a 1-to-0 change, its falling history word does.
- R9: Word 0 of each bank holds the direction bit at bit 31, the U level at bit 30, the V level at bit 29 and the W level at bit 28, with the U count in the low CNT_W bits. Words 1 and 2 hold the V and W counts. Word 3 holds the timer. All unused bits are 0.
- R10: A high cnt_clr on an edge zeroes all counters, the timer, all three stored copies and all history words, and sends the next snap load to bank 2. The sampled levels are kept.
- R11: rd_data shows, one clock after rd_addr is presented, the word selected by the following map. Addresses 0 to 15 select bank rd_addr[3:2] and word rd_addr[1:0]. Addresses 16 to 21 select history word {signal = rd_addr[2:1] (0 U, 1 V, 2 W), falling = rd_addr[0]}. Every other address reads 0.
- R12: After reset all stored copies, history words and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| u_in | input | 1 | Synchronized U level |
| v_in | input | 1 | Synchronized V level |
| w_in | input | 1 | Synchronized W level |
| dir_in | input | 1 | Rotation direction from the phase logic, 1 = reverse |
| evt_pulse | input | NUM_EVT | One-cycle phase event pulses (watchdog, update, pre, delay, U, V, W) |
| evt_load_en | input | NUM_EVT | Per-event enable for loading the read copy |
| rd_cmd | input | 1 | Read command strobe |
| snap_en | input | 1 | Allows snap_in to load the snapshot copies |
| snap_in | input | 1 | External snap request, acts on its rising edge |
| cnt_clr | input | 1 | Clear of counters, copies and history |
| rd_addr | input | 5 | Read port address |
| rd_data | output | DATA_W | Registered read data |

## Verification
A load caused by rd_cmd, an enabled event or a snap edge takes effect on the clock edge that samples the strobe. The copy therefore holds the counts from before that edge, which is where the k-1 of R1 comes from. Read data lags rd_addr by exactly one edge. Every bench task drives its inputs on falling edges and counts those edges between strobes, so each expected value follows from the number of rising edges in between. Timer checks use differences between two captures, never absolute values. Saturation is reached by building the bench with a narrow counter.

// File: rtl/hall_cap_pkg.sv
package hall_cap_pkg;
  localparam int NUM_SIG   = 3;   // U, V, W
  localparam int NUM_WORDS = 4;   // words per bank
  localparam int NUM_STORE = 3;   // read, snap A, snap B
  localparam int ADDR_W    = 5;

  // word positions inside a bank
  localparam int WORD_U   = 0;
  localparam int WORD_V   = 1;
  localparam int WORD_W   = 2;
  localparam int WORD_TMR = 3;

  // stored copy index (bank number minus one)
  typedef enum logic [1:0] {
    STORE_READ  = 2'd0,
    STORE_SNAPA = 2'd1,
    STORE_SNAPB = 2'd2
  } store_e;
endpackage

// File: rtl/hall_edge_counter.sv
module hall_edge_counter #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             lvl_in,
  output logic             lvl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] hist_rise_q,
  output logic [CNT_W-1:0] hist_fall_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic edge_s;
  assign edge_s = lvl_in ^ lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_in;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q       <= '0;
      hist_rise_q <= '0;
      hist_fall_q <= '0;
    end else begin
      if (edge_s)              cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      if (edge_s && lvl_in)    hist_rise_q <= cnt_q;
      if (edge_s && !lvl_in)   hist_fall_q <= cnt_q;
    end
  end

  // R1: restart on a level change
  p_restart_r1: assert property (@(posedge clk) disable iff (rst)
    edge_s |=> (cnt_q == '0));
  // R1: one step per clock while no edge
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!edge_s && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R2: saturation holds
  p_saturate_r2: assert property (@(posedge clk) disable iff (rst)
    (!edge_s && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  // R8: rising history takes the pre-edge count
  p_hist_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (edge_s && lvl_in && !clr) |=> (hist_rise_q == $past(cnt_q)));
  // R8: falling history takes the pre-edge count
  p_hist_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (edge_s && !lvl_in && !clr) |=> (hist_fall_q == $past(cnt_q)));
endmodule

// File: rtl/hall_bank_store.sv
module hall_bank_store
  import hall_cap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              clr,
  input  logic                                              rd_load,
  input  logic                                              snap_load,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0]                  live_words,
  output logic [NUM_STORE-1:0][NUM_WORDS-1:0][DATA_W-1:0]   stored_q
);
  logic                 snap_ptr_q;  // 0: next snap goes to A
  logic [NUM_STORE-1:0] load_vec;

  always_comb begin
    load_vec              = '0;
    load_vec[STORE_READ]  = rd_load;
    load_vec[STORE_SNAPA] = snap_load && !snap_ptr_q;
    load_vec[STORE_SNAPB] = snap_load &&  snap_ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)     snap_ptr_q <= 1'b0;
    else if (snap_load) snap_ptr_q <= ~snap_ptr_q;
  end

  for (genvar b = 0; b < NUM_STORE; b++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst || clr)       stored_q[b] <= '0;
      else if (load_vec[b]) stored_q[b] <= live_words;
    end
  end

  // R4: read copy takes the live words on the strobe edge
  p_read_load_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_load && !clr) |=> (stored_q[STORE_READ] == $past(live_words)));
  // R6: snap target alternates
  p_snap_alt_r6: assert property (@(posedge clk) disable iff (rst)
    (snap_load && !clr) |=> (snap_ptr_q != $past(snap_ptr_q)));
  // R10: clear empties every copy
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (stored_q == '0 && !snap_ptr_q));
endmodule

// File: rtl/hall_capture_unit.sv
module hall_capture_unit
  import hall_cap_pkg::*;
#(
  parameter int CNT_W   = 28,
  parameter int TMR_W   = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               u_in,
  input  logic               v_in,
  input  logic               w_in,
  input  logic               dir_in,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EVT-1:0] evt_load_en,
  input  logic               rd_cmd,
  input  logic               snap_en,
  input  logic               snap_in,
  input  logic               cnt_clr,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data
);
  logic [NUM_SIG-1:0]                                  lvl_in_vec;
  logic [NUM_SIG-1:0]                                  lvl_q;
  logic [NUM_SIG-1:0][CNT_W-1:0]                       cnt_q;
  logic [NUM_SIG-1:0][CNT_W-1:0]                       hist_rise_q;
  logic [NUM_SIG-1:0][CNT_W-1:0]                       hist_fall_q;
  logic [TMR_W-1:0]                                    tmr_q;
  logic                                                dir_q;
  logic                                                snap_q;
  logic                                                snap_load;
  logic                                                rd_load;
  logic [NUM_WORDS-1:0][DATA_W-1:0]                    live_w;
  logic [NUM_STORE-1:0][NUM_WORDS-1:0][DATA_W-1:0]     stored_q;
  logic [DATA_W-1:0]                                   rd_next;
  logic                                                addr_hole;

  assign lvl_in_vec = {w_in, v_in, u_in};

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    hall_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .clr         (cnt_clr),
      .lvl_in      (lvl_in_vec[s]),
      .lvl_q       (lvl_q[s]),
      .cnt_q       (cnt_q[s]),
      .hist_rise_q (hist_rise_q[s]),
      .hist_fall_q (hist_fall_q[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) tmr_q <= '0;
    else                tmr_q <= tmr_q + TMR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      dir_q  <= dir_in;
      snap_q <= snap_in;
    end
  end

  assign snap_load = snap_en && snap_in && !snap_q;
  assign rd_load   = rd_cmd || (|(evt_pulse & evt_load_en));

  always_comb begin
    live_w = '0;
    live_w[WORD_U][CNT_W-1:0]   = cnt_q[0];
    live_w[WORD_U][DATA_W-1]    = dir_q;
    live_w[WORD_U][DATA_W-2]    = lvl_q[0];
    live_w[WORD_U][DATA_W-3]    = lvl_q[1];
    live_w[WORD_U][DATA_W-4]    = lvl_q[2];
    live_w[WORD_V][CNT_W-1:0]   = cnt_q[1];
    live_w[WORD_W][CNT_W-1:0]   = cnt_q[2];
    live_w[WORD_TMR][TMR_W-1:0] = tmr_q;
  end

  hall_bank_store #(.DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .clr        (cnt_clr),
    .rd_load    (rd_load),
    .snap_load  (snap_load),
    .live_words (live_w),
    .stored_q   (stored_q)
  );

  assign addr_hole = rd_addr[4] && (rd_addr[3] || rd_addr[2:1] == 2'b11);

  always_comb begin
    rd_next = '0;
    if (!rd_addr[4]) begin
      if (rd_addr[3:2] == 2'd0) rd_next = live_w[rd_addr[1:0]];
      else                      rd_next = stored_q[rd_addr[3:2] - 2'd1][rd_addr[1:0]];
    end else if (!addr_hole) begin
      if (rd_addr[0]) rd_next[CNT_W-1:0] = hist_fall_q[rd_addr[2:1]];
      else            rd_next[CNT_W-1:0] = hist_rise_q[rd_addr[2:1]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R3: timer steps by one and wraps
  p_timer_step_r3: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> (tmr_q == $past(tmr_q) + TMR_W'(1)));
  // R11: unmapped addresses read zero
  p_hole_zero_r11: assert property (@(posedge clk) disable iff (rst)
    addr_hole |=> (rd_data == '0));
  // R6: no snap load while disabled
  p_snap_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (!snap_en && !rd_load && !cnt_clr) |=> $stable(stored_q[STORE_SNAPA]) && $stable(stored_q[STORE_SNAPB]));
endmodule

// File: tb/hall_capture_unit_bench.sv
`timescale 1ns/1ps
module hall_capture_unit_bench;
  localparam int CW = 8;  // narrow counter so saturation is reachable

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        u_in = 0, v_in = 0, w_in = 0, dir_in = 0;
  logic [6:0]  evt_pulse = '0, evt_load_en = '0;
  logic        rd_cmd = 0, snap_en = 0, snap_in = 0, cnt_clr = 0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  hall_capture_unit #(.CNT_W(CW)) u_hall_capture_unit (
    .clk(clk), .rst(rst), .u_in(u_in), .v_in(v_in), .w_in(w_in),
    .dir_in(dir_in), .evt_pulse(evt_pulse), .evt_load_en(evt_load_en),
    .rd_cmd(rd_cmd), .snap_en(snap_en), .snap_in(snap_in),
    .cnt_clr(cnt_clr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk) rd_addr = a;
    @(negedge clk) d = rd_data;
  endtask

  task automatic pulse_cmd();
    @(negedge clk) rd_cmd = 1;
    @(negedge clk) rd_cmd = 0;
  endtask

  task automatic pulse_snap();
    @(negedge clk) snap_in = 1;
    @(negedge clk) snap_in = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'd4, d);  chk("R12 read copy", d, 0);
    rd(5'd11, d); chk("R12 snap copy", d, 0);
    rd(5'd16, d); chk("R12 history", d, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    @(negedge clk) u_in = 1;
    repeat (10) @(negedge clk);
    rd_cmd = 1;
    @(negedge clk) rd_cmd = 0;
    rd(5'd4, d); chk("R1 R4 R9 U word after 10 clocks", d, 32'h4000_0009);
    @(negedge clk) w_in = 1;
    repeat (3) @(negedge clk);
    rd_cmd = 1;
    @(negedge clk) rd_cmd = 0;
    rd(5'd6, d); chk("R1 W count", d, 32'd2);
  endtask

  task automatic t_history();
    logic [31:0] d;
    @(negedge clk) u_in = 0;
    repeat (5) @(negedge clk);
    u_in = 1;
    repeat (7) @(negedge clk);
    u_in = 0;
    rd(5'd16, d); chk("R8 U rising history", d, 32'd4);
    rd(5'd17, d); chk("R8 U falling history", d, 32'd6);
    rd(5'd18, d); chk("R8 V untouched history", d, 32'd0);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    @(negedge clk) v_in = 1;
    repeat (300) @(negedge clk);
    pulse_cmd();
    rd(5'd5, d); chk("R2 V saturates", d, 32'd255);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    @(negedge clk) dir_in = 1;
    repeat (2) @(negedge clk);
    rd(5'd0, d); chk("R9 live flags", {28'd0, d[31:28]}, 32'hB);
    pulse_cmd();
    rd(5'd4, d); chk("R9 read copy flags", {28'd0, d[31:28]}, 32'hB);
  endtask

  task automatic t_timer();
    logic [31:0] a, b;
    rd(5'd3, a);
    repeat (10) @(negedge clk);
    rd(5'd3, b);
    chk("R3 timer delta", b - a, 32'd12);
  endtask

  task automatic t_events();
    logic [31:0] r0, d;
    evt_load_en = 7'b001_0000;
    pulse_cmd();
    rd(5'd7, r0);
    @(negedge clk) evt_pulse = 7'b000_0100;
    @(negedge clk) evt_pulse = '0;
    rd(5'd7, d); chk("R5 disabled event ignored", d, r0);
    @(negedge clk) evt_pulse = 7'b001_0000;
    @(negedge clk) evt_pulse = '0;
    rd(5'd7, d); chk("R5 enabled event loads", d, r0 + 32'd8);
  endtask

  task automatic t_snap();
    logic [31:0] sa, d, e;
    snap_en = 0;
    pulse_snap();
    rd(5'd11, d); chk("R6 snap disabled", d, 0);
    snap_en = 1;
    pulse_snap();
    rd(5'd11, sa);
    chk("R6 first snap to bank 2", (sa != 0) ? 32'd1 : 32'd0, 32'd1);
    pulse_snap();
    rd(5'd15, d); chk("R6 second snap to bank 3", d, sa + 32'd4);
    rd(5'd11, d); chk("R6 bank 2 kept", d, sa);
    pulse_snap();
    rd(5'd11, d); chk("R6 third snap back to bank 2", d, sa + 32'd10);
    rd(5'd15, d); chk("R6 bank 3 kept", d, sa + 32'd4);
    @(negedge clk) begin rd_cmd = 1; snap_in = 1; end
    @(negedge clk) begin rd_cmd = 0; snap_in = 0; end
    rd(5'd7, d); rd(5'd15, e); chk("R7 same timer", e, d);
    rd(5'd4, d); rd(5'd12, e); chk("R7 same U word", e, d);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    @(negedge clk) cnt_clr = 1;
    @(negedge clk) cnt_clr = 0;
    rd(5'd4, d);  chk("R10 read U", d, 0);
    rd(5'd7, d);  chk("R10 read timer", d, 0);
    rd(5'd8, d);  chk("R10 snap A", d, 0);
    rd(5'd11, d); chk("R10 snap A timer", d, 0);
    rd(5'd15, d); chk("R10 snap B timer", d, 0);
    rd(5'd16, d); chk("R10 history rise", d, 0);
    rd(5'd17, d); chk("R10 history fall", d, 0);
    pulse_snap();
    rd(5'd11, d); chk("R10 pointer back to bank 2", d, 32'd15);
    rd(5'd15, d); chk("R10 bank 3 still clear", d, 0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    rd(5'd22, d); chk("R11 hole 22", d, 0);
    rd(5'd31, d); chk("R11 hole 31", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_restart();
    t_history();
    t_saturate();
    t_flags();
    t_timer();
    t_events();
    t_snap();
    t_clear();
    t_addr();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule